// File: doc/BRIEF.md
# Table-Driven Power Sequencing Engine

This block sequences a board's supply rails from a state table held in on-chip registers. Each table entry describes one step of the sequence. It gives the levels of eight driver outputs, a sequence condition with a dwell delay and its own next step, an optional timeout with a separate next step, and a guard condition with its own next step. The guard condition catches supply faults and raises an alert. The inputs are supervised supply-good flags and plain logic inputs. A simple write port loads the table.

In each cycle the engine picks one of four transitions for the current step. A **guard** jump is taken when a watched input leaves its expected level. A **sequence** advance is taken when the sequence condition has held for its whole dwell. A **timeout** jump is taken when the step has lasted its programmed length. Otherwise the engine **holds**. A step whose sequence target is itself, with a timeout that leads to a fault step, acts as a watchdog: a toggling input keeps restarting the step's timers.

Top module: `seq_engine`

## Requirements
- R1: While `rst` is high the current step is 0, `drv_out` is all zeros and `alert` is low.
- R2: `drv_out` takes the levels of the step the engine enters at the same clock edge as the change of step. After `rst` is released, the first edge loads the levels of step 0.
- R3: The sequence condition is true when every input selected by the sequence mask equals its bit in the sequence polarity. An empty mask is always true. With dwell D, the engine advances to the sequence target at the (D+1)-th consecutive edge at which the condition is true.
- R4: An edge at which the sequence condition is false restarts the dwell count from zero.
- R5: With a timeout length T greater than 0, a step whose guard and sequence transitions do not fire lasts exactly T cycles and then moves to the timeout target. T equal to 0 disables the timeout.
- R6: When the sequence and timeout transitions fire at the same edge, the sequence target wins.
- R7: The guard fires when any input selected by the guard mask differs from its bit in the guard polarity. The guard target then wins over both other transitions, and `alert` is high for exactly the one cycle that follows.
- R8: Every transition, including one back to the same step, restarts both the dwell count and the step-length count.
- R9: A write with `tbl_we` high stores `tbl_wdata` as the entry at `tbl_addr`. Bit fields, LSB first: guard target [5:0], guard polarity [13:6], guard mask [21:14], timeout target [27:22], timeout length [35:28], sequence target [41:36], dwell [49:42], sequence polarity [57:50], sequence mask [65:58], output levels [73:66].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sup_in | input | 8 | Supply-good flags and logic inputs |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table entry index |
| tbl_wdata | input | 74 | Table entry contents |
| drv_out | output | 8 | Driver output levels |
| cur_state | output | 6 | Index of the current step |
| alert | output | 1 | One-cycle pulse after a guard jump |

## Verification
The bench builds the block with its default parameters: eight inputs, eight outputs, a 64-entry table and 8-bit dwell and timeout counts. These small counts let the bench sweep dwell values 0 to 5 and timeout lengths 1 to 5 against cycle counts worked out in the bench. It also moves a guard on each of the eight inputs in turn, in both the firing and the non-firing case. Edges at which the sequence and timeout transitions fire together are placed on purpose, as are condition drops in the middle of a dwell and a timeout counted from entry to a step reached through a dwell.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [1:0] {
        XFER_HOLD  = 2'd0,
        XFER_GUARD = 2'd1,
        XFER_SEQ   = 2'd2,
        XFER_TMO   = 2'd3
    } xfer_t;
endpackage

// File: rtl/seq_table.sv
module seq_table #(
    parameter int SW = 6,
    parameter int EW = 74,
    parameter int NO = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [SW-1:0] ra_addr,
    output logic [EW-1:0] ra_data,
    input  logic [SW-1:0] lv_addr,
    output logic [NO-1:0] lv_data
);
    localparam int DEPTH = 1 << SW;

    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign ra_data = mem[ra_addr];
    assign lv_data = mem[lv_addr][EW-1 -: NO];
endmodule

// File: rtl/seq_cond.sv
module seq_cond #(
    parameter int NI = 8,
    parameter int DW = 8
) (
    input  logic [NI-1:0] sup_in,
    input  logic [NI-1:0] s_mask,
    input  logic [NI-1:0] s_pol,
    input  logic [DW-1:0] s_dly,
    input  logic [DW-1:0] dwell,
    input  logic [DW-1:0] t_len,
    input  logic [DW-1:0] age,
    input  logic [NI-1:0] g_mask,
    input  logic [NI-1:0] g_pol,
    output logic          seq_ok,
    output logic          seq_fire,
    output logic          tmo_fire,
    output logic          guard_hit
);
    assign seq_ok    = ((sup_in ^ s_pol) & s_mask) == '0;
    assign seq_fire  = seq_ok && (dwell == s_dly);
    assign tmo_fire  = (t_len != '0) && (age == t_len - 1'b1);
    assign guard_hit = |((sup_in ^ g_pol) & g_mask);
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          seq_ok,
    output logic [DW-1:0] dwell,
    output logic [DW-1:0] age
);
    localparam logic [DW-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            dwell <= '0;
            age   <= '0;
        end else begin
            dwell <= !seq_ok ? '0 : (dwell != TOP ? dwell + 1'b1 : dwell);
            age   <= (age != TOP) ? age + 1'b1 : age;
        end
    end

    a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (dwell == '0 && age == '0));
    a_r4_drop_clears: assert property (@(posedge clk) disable iff (rst)
        !seq_ok |=> dwell == '0);
endmodule

// File: rtl/seq_engine.sv
module seq_engine #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8,
    parameter int SW    = 6,
    parameter int DW    = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [N_IN-1:0]                     sup_in,
    input  logic                                tbl_we,
    input  logic [SW-1:0]                       tbl_addr,
    input  logic [3*SW+4*N_IN+2*DW+N_OUT-1:0]   tbl_wdata,
    output logic [N_OUT-1:0]                    drv_out,
    output logic [SW-1:0]                       cur_state,
    output logic                                alert
);
    import seq_pkg::*;

    localparam int OFF_GP = SW;
    localparam int OFF_GM = SW + N_IN;
    localparam int OFF_TN = SW + 2*N_IN;
    localparam int OFF_TL = 2*SW + 2*N_IN;
    localparam int OFF_SN = 2*SW + 2*N_IN + DW;
    localparam int OFF_SD = 3*SW + 2*N_IN + DW;
    localparam int OFF_SP = 3*SW + 2*N_IN + 2*DW;
    localparam int OFF_SM = 3*SW + 3*N_IN + 2*DW;
    localparam int EW     = 3*SW + 4*N_IN + 2*DW + N_OUT;

    logic [EW-1:0]    ent;
    logic [N_OUT-1:0] nxt_lvl;
    logic [SW-1:0]    nxt;
    logic [DW-1:0]    dwell, age;
    logic             seq_ok, seq_fire, tmo_fire, guard_hit, restart;
    xfer_t            kind;

    logic [SW-1:0]    g_next, t_next, s_next;
    logic [N_IN-1:0]  g_pol, g_mask, s_pol, s_mask;
    logic [DW-1:0]    t_len, s_dly;

    assign g_next = ent[SW-1:0];
    assign g_pol  = ent[OFF_GP +: N_IN];
    assign g_mask = ent[OFF_GM +: N_IN];
    assign t_next = ent[OFF_TN +: SW];
    assign t_len  = ent[OFF_TL +: DW];
    assign s_next = ent[OFF_SN +: SW];
    assign s_dly  = ent[OFF_SD +: DW];
    assign s_pol  = ent[OFF_SP +: N_IN];
    assign s_mask = ent[OFF_SM +: N_IN];

    seq_table #(.SW(SW), .EW(EW), .NO(N_OUT)) u_tbl (
        .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
        .ra_addr(cur_state), .ra_data(ent),
        .lv_addr(nxt), .lv_data(nxt_lvl)
    );

    seq_cond #(.NI(N_IN), .DW(DW)) u_cond (
        .sup_in(sup_in), .s_mask(s_mask), .s_pol(s_pol), .s_dly(s_dly),
        .dwell(dwell), .t_len(t_len), .age(age),
        .g_mask(g_mask), .g_pol(g_pol),
        .seq_ok(seq_ok), .seq_fire(seq_fire), .tmo_fire(tmo_fire),
        .guard_hit(guard_hit)
    );

    seq_timer #(.DW(DW)) u_tmr (
        .clk(clk), .rst(rst), .restart(restart), .seq_ok(seq_ok),
        .dwell(dwell), .age(age)
    );

    // Transition choice: guard, then sequence, then timeout.
    always_comb begin
        if (guard_hit)     kind = XFER_GUARD;
        else if (seq_fire) kind = XFER_SEQ;
        else if (tmo_fire) kind = XFER_TMO;
        else               kind = XFER_HOLD;
    end

    always_comb begin
        unique case (kind)
            XFER_GUARD: nxt = g_next;
            XFER_SEQ:   nxt = s_next;
            XFER_TMO:   nxt = t_next;
            default:    nxt = cur_state;
        endcase
    end

    assign restart = (kind != XFER_HOLD);

    // State register
    always_ff @(posedge clk) begin
        if (rst) cur_state <= '0;
        else     cur_state <= nxt;
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            drv_out <= '0;
            alert   <= 1'b0;
        end else begin
            drv_out <= nxt_lvl;
            alert   <= (kind == XFER_GUARD);
        end
    end

    a_r7_guard_jump: assert property (@(posedge clk) disable iff (rst)
        guard_hit |=> cur_state == $past(g_next));
    a_r7_alert_cause: assert property (@(posedge clk) disable iff (rst)
        alert |-> $past(guard_hit));
    a_r6_seq_wins: assert property (@(posedge clk) disable iff (rst)
        (seq_fire && !guard_hit) |=> cur_state == $past(s_next));
    a_r5_tmo_jump: assert property (@(posedge clk) disable iff (rst)
        (tmo_fire && !seq_fire && !guard_hit) |=> cur_state == $past(t_next));
    a_r3_no_early_move: assert property (@(posedge clk) disable iff (rst)
        (!guard_hit && !seq_fire && !tmo_fire) |=> $stable(cur_state));
endmodule

// File: tb/sim_seq_engine.sv
module sim_seq_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  sup_in = '0;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_addr = '0;
    logic [73:0] tbl_wdata = '0;
    logic [7:0]  drv_out;
    logic [5:0]  cur_state;
    logic        alert;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    seq_engine u0 (
        .clk(clk), .rst(rst), .sup_in(sup_in), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .drv_out(drv_out), .cur_state(cur_state), .alert(alert)
    );

    function automatic logic [73:0] ent(
        input logic [7:0] lvl, input logic [7:0] smask, input logic [7:0] spol,
        input logic [7:0] sdly, input logic [5:0] snext, input logic [7:0] tlen,
        input logic [5:0] tnext, input logic [7:0] gmask, input logic [7:0] gpol,
        input logic [5:0] gnext);
        return {lvl, smask, spol, sdly, snext, tlen, tnext, gmask, gpol, gnext};
    endfunction

    // Step that loops on itself every cycle.
    function automatic logic [73:0] hold(input logic [7:0] lvl, input logic [5:0] self);
        return ent(lvl, 8'h00, 8'h00, 8'd0, self, 8'd0, 6'd0, 8'h00, 8'h00, 6'd0);
    endfunction

    task automatic put(input logic [5:0] a, input logic [73:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic go();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1, R9, R2: reset state then step-0 levels
        put(0, ent(8'hA5, 8'h80, 8'h80, 8'd0, 6'd0, 8'd0, 6'd0, 8'h00, 8'h00, 6'd0));
        step(1);
        chk("R1 drv_out", 32'(drv_out), 32'h0);
        chk("R1 state", 32'(cur_state), 32'h0);
        chk("R1 alert", 32'(alert), 32'h0);
        go(); step(1);
        chk("R2 R9 levels of step 0", 32'(drv_out), 32'hA5);
        rst = 1'b1; step(1);
        chk("R1 drv_out cleared", 32'(drv_out), 32'h0);

        // R3: dwell sweep
        for (int d = 0; d <= 5; d++) begin
            put(0, ent(8'h01, 8'h01, 8'h01, 8'(d), 6'd1, 8'd0, 6'd0, 8'h00, 8'h00, 6'd0));
            put(1, hold(8'h02, 6'd1));
            sup_in = 8'h00;
            go(); step(1);
            chk("R3 idle in step 0", 32'(cur_state), 32'd0);
            sup_in = 8'h01;
            for (int k = 1; k <= d; k++) begin
                step(1);
                chk("R3 still dwelling", 32'(cur_state), 32'd0);
            end
            step(1);
            chk("R3 advance after dwell", 32'(cur_state), 32'd1);
            chk("R2 levels of new step", 32'(drv_out), 32'h02);
        end

        // R4: drop mid-dwell restarts it
        put(0, ent(8'h01, 8'h01, 8'h01, 8'd4, 6'd1, 8'd0, 6'd0, 8'h00, 8'h00, 6'd0));
        sup_in = 8'h01;
        go(); step(3);
        sup_in = 8'h00; step(1);
        sup_in = 8'h01; step(4);
        chk("R4 dwell restarted", 32'(cur_state), 32'd0);
        step(1);
        chk("R4 advance after full dwell", 32'(cur_state), 32'd1);

        // R5: timeout sweep
        sup_in = 8'h00;
        put(2, hold(8'h04, 6'd2));
        for (int t = 1; t <= 5; t++) begin
            put(0, ent(8'h10, 8'h80, 8'h80, 8'd0, 6'd0, 8'(t), 6'd2, 8'h00, 8'h00, 6'd0));
            go();
            if (t > 1) begin
                step(t - 1);
                chk("R5 before expiry", 32'(cur_state), 32'd0);
                step(1);
            end else step(1);
            chk("R5 timeout target", 32'(cur_state), 32'd2);
            chk("R5 timeout levels", 32'(drv_out), 32'h04);
        end
        put(0, ent(8'h10, 8'h80, 8'h80, 8'd0, 6'd0, 8'd0, 6'd2, 8'h00, 8'h00, 6'd0));
        go(); step(20);
        chk("R5 zero length disables", 32'(cur_state), 32'd0);

        // R6: sequence beats timeout at the same edge
        put(1, hold(8'h02, 6'd1));
        put(0, ent(8'h01, 8'h00, 8'h00, 8'd2, 6'd1, 8'd3, 6'd2, 8'h00, 8'h00, 6'd0));
        go(); step(3);
        chk("R6 sequence wins tie", 32'(cur_state), 32'd1);
        put(0, ent(8'h01, 8'h00, 8'h00, 8'd3, 6'd1, 8'd3, 6'd2, 8'h00, 8'h00, 6'd0));
        go(); step(3);
        chk("R6 earlier timeout taken", 32'(cur_state), 32'd2);

        // R8: timeout counted from entry to the new step
        put(0, ent(8'h01, 8'h00, 8'h00, 8'd2, 6'd1, 8'd0, 6'd0, 8'h00, 8'h00, 6'd0));
        put(1, ent(8'h02, 8'h80, 8'h80, 8'd0, 6'd1, 8'd3, 6'd2, 8'h00, 8'h00, 6'd0));
        go(); step(3);
        chk("R8 entered step 1", 32'(cur_state), 32'd1);
        step(2);
        chk("R8 step 1 timer fresh", 32'(cur_state), 32'd1);
        step(1);
        chk("R8 step 1 lasted 3", 32'(cur_state), 32'd2);

        // R7: guard on each input
        put(1, hold(8'h02, 6'd1));
        put(3, hold(8'h08, 6'd3));
        for (int b = 0; b < 8; b++) begin
            put(0, ent(8'h01, 8'h00, 8'h00, 8'd0, 6'd1, 8'd0, 6'd0, 8'(1 << b), 8'h00, 6'd3));
            sup_in = 8'(1 << b);
            go(); step(1);
            chk("R7 guard target", 32'(cur_state), 32'd3);
            chk("R7 alert raised", 32'(alert), 32'd1);
            chk("R7 guard levels", 32'(drv_out), 32'h08);
            step(1);
            chk("R7 alert one cycle", 32'(alert), 32'd0);
            sup_in = ~8'(1 << b);
            go(); step(1);
            chk("R7 no guard, sequence taken", 32'(cur_state), 32'd1);
            chk("R7 no alert", 32'(alert), 32'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule